// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

This unit keeps the single local reservation bit that an in-order core needs for word-sized load-reserved (lr) and store-conditional (sc) accesses. It watches the memory-stage operation offered on a valid/ready stream, gates the matching bus request, reads the data-phase response (ready, error and exclusive-okay), and updates the reservation. It also produces the sc result value, the register writeback enable and any access-fault cause.

An sc issued with the reservation clear never reaches the bus. It retires in the cycle it is offered, writes 0 and raises nothing. A load-reserved that faults always leaves the reservation clear, even if the bus reports exclusive-okay together with the error. A faulting sc clears the reservation and does not write its destination register, so a repeated sc to the same bad address is suppressed.

The operation stream follows these rules. The producer holds `op_valid` and `op_kind` steady until it sees `op_ready`. An issued operation completes in the first cycle with `bus_ready` high. A suppressed sc completes in the cycle it is offered. The bus response inputs are sampled only while an issued operation is pending. Writeback, result and exception outputs are valid only in the completion cycle.

Top module: `resv_monitor`

## Requirements
- R1: After the active-low asynchronous reset, `resv_flag` is 0.
- R2: When `dec_amo` is high at a clock edge, `resv_flag` is 0 after that edge, whatever operation completes in the same cycle.
- R3: A load-reserved (`op_kind` 2) that completes with `bus_ready` sets `resv_flag` to `bus_exokay` AND NOT `bus_err` at the next edge. While it waits with `bus_ready` low, the flag keeps its value.
- R4: A store-conditional (`op_kind` 3) clears `resv_flag` at the edge after it completes. While an issued sc waits with `bus_ready` low, the flag keeps its value.
- R5: An sc offered while `resv_flag` is 0 is suppressed. In that cycle `bus_req` is 0, `op_ready` is 1, `exc_valid` is 0, `wb_en` is 1 and `sc_result` is 0.
- R6: An issued sc that completes without error drives `wb_en` 1. It drives `sc_result` 0 when `bus_exokay` is 1 and 1 otherwise.
- R7: An issued sc that completes with `bus_err` drives `exc_valid` 1, `exc_cause` 7 and `wb_en` 0.
- R8: A load (`op_kind` 0) or load-reserved that completes with `bus_err` drives `exc_valid` 1, `exc_cause` 5 and `wb_en` 0. One that completes without error drives `wb_en` 1.
- R9: A plain store (`op_kind` 1) never drives `wb_en`. When it completes with `bus_err` it drives `exc_valid` 1 and `exc_cause` 7.
- R10: Outside a suppressed sc, `bus_req` equals `op_valid`, and `op_ready` equals `op_valid` AND `bus_ready`. `exc_valid` and `wb_en` are high only in a completion cycle. `sc_result` is 0 unless an issued sc is retiring.
- R11: Plain loads and stores leave `resv_flag` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dec_amo | input | 1 | An atomic memory operation is in decode |
| op_valid | input | 1 | Memory-stage operation offered |
| op_ready | output | 1 | Operation completes this cycle |
| op_kind | input | 2 | 0 load, 1 store, 2 load-reserved, 3 store-conditional |
| bus_req | output | 1 | Operation is placed on the data bus |
| bus_ready | input | 1 | Data phase completes |
| bus_err | input | 1 | Data phase error response |
| bus_exokay | input | 1 | Exclusive access okay |
| wb_en | output | 1 | Destination register is written |
| sc_result | output | DATA_W | Value written by an sc |
| exc_valid | output | 1 | Access-fault exception strobe |
| exc_cause | output | CAUSE_W | Exception cause code |
| resv_flag | output | 1 | Local reservation state |

## Verification
On every cycle, the assertions check four things: that atomics and completed sc operations clear the reservation, that a faulting lr leaves it clear, that plain loads and stores leave it untouched, and that suppressed sc operations never touch the bus. They also check that an sc fault never writes back and that exceptions only appear at completion. Only the bench's scenarios can show the ordered effects: a failed lr suppressing the next sc, a faulting sc suppressing its retry, and an atomic between lr and sc cancelling the pair. The bench also sweeps every operation kind against every flag state and response combination, with a wait cycle before each completion.

// File: rtl/resv_mon_pkg.sv
package resv_mon_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_LR    = 2'd2,
    OP_SC    = 2'd3
  } mem_op_e;
endpackage

// File: rtl/resv_issue_ctl.sv
module resv_issue_ctl
  import resv_mon_pkg::*;
(
  input  logic    op_valid,
  input  mem_op_e op_kind,
  input  logic    resv,
  input  logic    bus_ready,
  output logic    suppress,
  output logic    bus_req,
  output logic    op_ready,
  output logic    issued_done
);
  // An sc without a reservation retires at once and never reaches the bus.
  assign suppress    = op_valid && (op_kind == OP_SC) && !resv;
  assign bus_req     = op_valid && !suppress;
  assign issued_done = bus_req && bus_ready;
  assign op_ready    = suppress || issued_done;
endmodule

// File: rtl/resv_flag_reg.sv
module resv_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_amo,
  input  logic sc_done,
  input  logic lr_done,
  input  logic lr_value,
  output logic flag
);
  // Priority: atomic in decode, then sc completion, then lr completion.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (clr_amo) flag <= 1'b0;
    else if (sc_done) flag <= 1'b0;
    else if (lr_done) flag <= lr_value;
  end
endmodule

// File: rtl/resv_retire.sv
module resv_retire
  import resv_mon_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int CAUSE_W     = 4,
  parameter int LOAD_CAUSE  = 5,
  parameter int STORE_CAUSE = 7
) (
  input  mem_op_e             op_kind,
  input  logic                suppress,
  input  logic                issued_done,
  input  logic                bus_err,
  input  logic                bus_exokay,
  output logic                exc_valid,
  output logic [CAUSE_W-1:0]  exc_cause,
  output logic                wb_en,
  output logic [DATA_W-1:0]   sc_result
);
  localparam logic [CAUSE_W-1:0] LD_C = CAUSE_W'(LOAD_CAUSE);
  localparam logic [CAUSE_W-1:0] ST_C = CAUSE_W'(STORE_CAUSE);
  localparam logic [DATA_W-1:0]  FAIL_V = DATA_W'(1);

  logic is_read, clean_done;

  assign is_read    = (op_kind == OP_LOAD) || (op_kind == OP_LR);
  assign clean_done = issued_done && !bus_err;

  always_comb begin
    exc_valid = issued_done && bus_err;
    exc_cause = '0;
    if (exc_valid) exc_cause = is_read ? LD_C : ST_C;
    wb_en     = suppress || (clean_done && (op_kind != OP_STORE));
    sc_result = '0;
    if (clean_done && (op_kind == OP_SC) && !bus_exokay) sc_result = FAIL_V;
  end
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_mon_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int CAUSE_W     = 4,
  parameter int LOAD_CAUSE  = 5,
  parameter int STORE_CAUSE = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dec_amo,
  input  logic               op_valid,
  output logic               op_ready,
  input  logic [1:0]         op_kind,
  output logic               bus_req,
  input  logic               bus_ready,
  input  logic               bus_err,
  input  logic               bus_exokay,
  output logic               wb_en,
  output logic [DATA_W-1:0]  sc_result,
  output logic               exc_valid,
  output logic [CAUSE_W-1:0] exc_cause,
  output logic               resv_flag
);
  mem_op_e kind;
  logic suppress, issued_done, sc_done, lr_done, lr_value;

  assign kind     = mem_op_e'(op_kind);
  assign sc_done  = op_ready && (kind == OP_SC);
  assign lr_done  = issued_done && (kind == OP_LR);
  // An erroring lr never leaves a reservation, whatever exclusive-okay says.
  assign lr_value = bus_exokay && !bus_err;

  resv_issue_ctl u_issue (
    .op_valid    (op_valid),
    .op_kind     (kind),
    .resv        (resv_flag),
    .bus_ready   (bus_ready),
    .suppress    (suppress),
    .bus_req     (bus_req),
    .op_ready    (op_ready),
    .issued_done (issued_done)
  );

  resv_flag_reg u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_amo  (dec_amo),
    .sc_done  (sc_done),
    .lr_done  (lr_done),
    .lr_value (lr_value),
    .flag     (resv_flag)
  );

  resv_retire #(
    .DATA_W      (DATA_W),
    .CAUSE_W     (CAUSE_W),
    .LOAD_CAUSE  (LOAD_CAUSE),
    .STORE_CAUSE (STORE_CAUSE)
  ) u_retire (
    .op_kind     (kind),
    .suppress    (suppress),
    .issued_done (issued_done),
    .bus_err     (bus_err),
    .bus_exokay  (bus_exokay),
    .exc_valid   (exc_valid),
    .exc_cause   (exc_cause),
    .wb_en       (wb_en),
    .sc_result   (sc_result)
  );
endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk #(
  parameter int DATA_W      = 32,
  parameter int CAUSE_W     = 4,
  parameter int STORE_CAUSE = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               dec_amo,
  input logic               op_valid,
  input logic               op_ready,
  input logic [1:0]         op_kind,
  input logic               bus_req,
  input logic               bus_ready,
  input logic               bus_err,
  input logic               wb_en,
  input logic [DATA_W-1:0]  sc_result,
  input logic               exc_valid,
  input logic [CAUSE_W-1:0] exc_cause,
  input logic               resv_flag
);
  // R2
  amo_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_amo |=> !resv_flag);

  // R4
  sc_done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == 2'd3 && op_ready) |=> !resv_flag);

  // R3
  lr_fault_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == 2'd2 && bus_ready && bus_err) |=> !resv_flag);

  // R5
  sc_suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == 2'd3 && !resv_flag) |->
      (!bus_req && op_ready && !exc_valid && wb_en && sc_result == '0));

  // R7
  sc_fault_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && op_kind == 2'd3) |->
      (!wb_en && exc_cause == CAUSE_W'(STORE_CAUSE)));

  // R11
  plain_keeps_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_kind[1] && !dec_amo) |=> $stable(resv_flag));

  // R10
  exc_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid || wb_en) |-> op_ready);
endmodule

bind resv_monitor resv_monitor_chk #(
  .DATA_W      (DATA_W),
  .CAUSE_W     (CAUSE_W),
  .STORE_CAUSE (STORE_CAUSE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dec_amo   (dec_amo),
  .op_valid  (op_valid),
  .op_ready  (op_ready),
  .op_kind   (op_kind),
  .bus_req   (bus_req),
  .bus_ready (bus_ready),
  .bus_err   (bus_err),
  .wb_en     (wb_en),
  .sc_result (sc_result),
  .exc_valid (exc_valid),
  .exc_cause (exc_cause),
  .resv_flag (resv_flag)
);

// File: tb/resv_monitor_test.sv
module resv_monitor_test;
  localparam int DW = 32;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dec_amo = 1'b0, op_valid = 1'b0, bus_ready = 1'b0, bus_err = 1'b0, bus_exokay = 1'b0;
  logic [1:0] op_kind = 2'd0;
  logic op_ready, bus_req, wb_en, exc_valid, resv_flag;
  logic [DW-1:0] sc_result;
  logic [CW-1:0] exc_cause;

  int n_chk = 0;
  int n_bad = 0;
  logic mflag = 1'b0;
  logic finished = 1'b0;

  always #4 clk = ~clk;

  resv_monitor #(.DATA_W(DW), .CAUSE_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .dec_amo(dec_amo), .op_valid(op_valid),
    .op_ready(op_ready), .op_kind(op_kind), .bus_req(bus_req),
    .bus_ready(bus_ready), .bus_err(bus_err), .bus_exokay(bus_exokay),
    .wb_en(wb_en), .sc_result(sc_result), .exc_valid(exc_valid),
    .exc_cause(exc_cause), .resv_flag(resv_flag)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check outputs mid-cycle, check flag after edge.
  task automatic cyc(input int kind, input logic valid, input logic rdy,
                     input logic err, input logic exo, input logic amo);
    logic supp, done, issued, exc;
    @(negedge clk);
    op_valid = valid; op_kind = kind[1:0]; bus_ready = rdy;
    bus_err = err; bus_exokay = exo; dec_amo = amo;
    supp   = valid && kind == 3 && !mflag;
    issued = valid && !supp && rdy;
    done   = supp || issued;
    exc    = issued && err;
    #2;
    chk("R10", "bus_req", int'(bus_req), int'(valid && !supp));
    chk("R10", "op_ready", int'(op_ready), int'(done));
    chk(kind == 1 ? "R9" : (kind == 3 ? "R7" : "R8"), "exc_valid", int'(exc_valid), int'(exc));
    if (exc) chk(kind[1] == kind[0] || kind == 2 ? (kind == 3 ? "R7" : "R8") : "R9",
                 "exc_cause", int'(exc_cause), (kind == 0 || kind == 2) ? 5 : 7);
    chk(supp ? "R5" : (kind == 3 ? "R6" : "R8"), "wb_en", int'(wb_en),
        int'(supp || (issued && !err && kind != 1)));
    chk(kind == 3 ? "R6" : "R10", "sc_result", int'(sc_result),
        (issued && !err && kind == 3 && !exo) ? 1 : 0);
    if (amo) mflag = 1'b0;
    else if (done && kind == 3) mflag = 1'b0;
    else if (issued && kind == 2) mflag = exo && !err;
    @(posedge clk); #1;
    chk(amo ? "R2" : (kind == 2 ? "R3" : (kind == 3 ? "R4" : "R11")), "resv_flag",
        int'(resv_flag), int'(mflag));
  endtask

  task automatic idle();
    cyc(0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #3;
    chk("R1", "resv_flag in reset", int'(resv_flag), 0);
    #20 rst_n = 1'b1;
    #1;
    chk("R1", "resv_flag after reset", int'(resv_flag), 0);
    idle();

    // Sweep: kind x start flag x err x exokay x amo, with a wait cycle first.
    for (int k = 0; k < 4; k++)
      for (int f = 0; f < 2; f++)
        for (int e = 0; e < 2; e++)
          for (int x = 0; x < 2; x++)
            for (int a = 0; a < 2; a++) begin
              if (f == 1) cyc(2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
              else        cyc(0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
              cyc(k, 1'b1, 1'b0, e[0], x[0], 1'b0);   // wait state
              cyc(k, 1'b1, 1'b1, e[0], x[0], a[0]);   // completion
              idle();
            end

    // R3 R5: lr faults (exokay wrongly high), then sc is suppressed.
    cyc(2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    cyc(2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    cyc(3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);

    // R7 R5: lr ok, sc faults, retried sc is suppressed.
    cyc(2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    cyc(3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    cyc(3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    cyc(3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);

    // R2: atomic between lr and sc cancels the pair.
    cyc(2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    idle();
    cyc(0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    cyc(3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);

    // R6 R11: lr ok, plain load and store between, sc succeeds.
    cyc(2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    cyc(0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    cyc(1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    cyc(3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    idle();

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule